// File: doc/BRIEF.md
# PCI Command and Status Error Control

This block keeps the error-control part of a PCI device's configuration header. Its inputs are single-cycle strobes from the bus engine, one per kind of parity event: an address parity error, a target-side data parity error, a data parity error during a Special Cycle, and a data parity error seen while this device is master. The stored command enables decide whether each event reaches the active-low PERR# and SERR# pins. Every detected event leaves a sticky mark in the status half of the command/status dword.

Command, status and latency-timer state are read and written through a simple dword-addressed configuration port with byte enables. The read path is combinational. A write lands on the next rising edge. The block also sits in the master's command path. A Memory Write and Invalidate request from the backend goes out as a plain Memory Write unless its enable is set.

Top module: `pci_err_ctl`

## Requirements
- R1: After reset, perr_n and serr_n are 1 and configuration reads of dword index 1 and dword index 3 return 0.
- R2: In dword index 1, command bits 3 (special-cycle snoop), 4 (MWI allowed) and 6 (parity response) are written through byte lane 0, and bit 8 (SERR# allowed) is written through byte lane 1. All other bits of the low half read as 0.
- R3: The latency timer is held in bits 15:8 of dword index 3. It is written only when byte enable 1 is set, and it reads back unchanged.
- R4: A target or master data parity strobe while bit 6 is set drives perr_n low for one cycle, two clocks after the strobe cycle. With bit 6 clear, perr_n stays high. A Special Cycle parity error never drives perr_n.
- R5: An address parity strobe pulses serr_n low one clock later only when bits 8 and 6 are both set.
- R6: A Special Cycle parity strobe pulses serr_n low one clock later only when bits 3 and 8 are both set.
- R7: serr_n is never low in two consecutive cycles, even when the triggering strobe is held.
- R8: When req_cmd is 4'b1111 (MWI) and bit 4 is clear, bus_cmd is 4'b0111 (Memory Write). In every other case bus_cmd equals req_cmd.
- R9: Status bit 15 (dword bit 31) is set by any of the four parity strobes, whatever the enables are.
- R10: Status bit 14 (dword bit 30) is set on the same edge that serr_n goes low.
- R11: Status bit 8 (dword bit 24) is set by a master data parity strobe only while command bit 6 is set.
- R12: A status bit is cleared only by a write to dword index 1 with byte enable 3 set and a 1 in that bit. Writing 0 leaves it unchanged. A strobe on the same edge as the clearing write keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword index of the configuration access |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| ev_addr_perr | input | 1 | Address parity error strobe |
| ev_data_perr | input | 1 | Target data parity error strobe |
| ev_spc_perr | input | 1 | Special Cycle data parity error strobe |
| ev_mst_perr | input | 1 | Master-detected data parity error strobe |
| req_cmd | input | 4 | Bus command requested by the backend |
| bus_cmd | output | 4 | Bus command to issue |
| perr_n | output | 1 | PERR# pin drive, active low |
| serr_n | output | 1 | SERR# pin drive, active low |
| lat_timer | output | 8 | Latency timer value |

## Verification
The bench walks every pairing of an event kind with the enable bits that should or should not let it through. A design that gates address errors with only the SERR# bit, or that routes Special Cycle errors onto PERR#, would pulse the wrong pin. The cycle of each pin is checked exactly, so a PERR# arriving one clock early or a SERR# held while its cause persists is caught. The sticky bits are tested for three things: that writing 0 leaves them set, that a strobe coinciding with the clearing write keeps them set, and that master-only status ignores events while parity response is off. Byte-enable masking, reserved command bits and non-MWI commands passing through unchanged are checked as well.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;

    // dword indices inside the configuration header
    localparam int unsigned CMD_DW = 1;
    localparam int unsigned LAT_DW = 3;

    // bit positions inside dword index 1
    localparam int unsigned B_SPC  = 3;
    localparam int unsigned B_MWI  = 4;
    localparam int unsigned B_PAR  = 6;
    localparam int unsigned B_SERR = 8;
    localparam int unsigned B_MST  = 24;
    localparam int unsigned B_SIG  = 30;
    localparam int unsigned B_DET  = 31;

    // latency timer lane inside dword index 3
    localparam int unsigned LAT_LSB = 8;

    localparam logic [3:0] BUS_MWI = 4'b1111;
    localparam logic [3:0] BUS_MWR = 4'b0111;

    typedef struct packed {
        logic serr_en;
        logic par_en;
        logic mwi_en;
        logic spc_en;
    } cmd_t;

    typedef struct packed {
        logic det;
        logic sig;
        logic mst;
    } stat_t;

endpackage

// File: rtl/pci_err_regs.sv
module pci_err_regs
    import pci_err_pkg::*;
#(
    parameter int unsigned AW    = 6,
    parameter int unsigned LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic             set_det,
    input  logic             set_sig,
    input  logic             set_mst,
    output cmd_t             cmd,
    output stat_t            stat,
    output logic [LAT_W-1:0] lat,
    output logic [31:0]      rdata
);

    typedef struct packed {
        cmd_t             cmd;
        stat_t            st;
        logic [LAT_W-1:0] lat;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_cmd, hit_lat;

    assign hit_cmd = wr && (addr == AW'(CMD_DW));
    assign hit_lat = wr && (addr == AW'(LAT_DW));

    always_comb begin
        r_d = r_q;
        if (hit_cmd && be[0]) begin
            r_d.cmd.spc_en = wdata[B_SPC];
            r_d.cmd.mwi_en = wdata[B_MWI];
            r_d.cmd.par_en = wdata[B_PAR];
        end
        if (hit_cmd && be[1]) begin
            r_d.cmd.serr_en = wdata[B_SERR];
        end
        if (hit_cmd && be[3]) begin
            if (wdata[B_DET]) r_d.st.det = 1'b0;
            if (wdata[B_SIG]) r_d.st.sig = 1'b0;
            if (wdata[B_MST]) r_d.st.mst = 1'b0;
        end
        if (hit_lat && be[1]) begin
            r_d.lat = wdata[LAT_LSB +: LAT_W];
        end
        // events override a clearing write on the same edge
        if (set_det) r_d.st.det = 1'b1;
        if (set_sig) r_d.st.sig = 1'b1;
        if (set_mst) r_d.st.mst = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(CMD_DW)) begin
            rdata[B_SPC]  = r_q.cmd.spc_en;
            rdata[B_MWI]  = r_q.cmd.mwi_en;
            rdata[B_PAR]  = r_q.cmd.par_en;
            rdata[B_SERR] = r_q.cmd.serr_en;
            rdata[B_DET]  = r_q.st.det;
            rdata[B_SIG]  = r_q.st.sig;
            rdata[B_MST]  = r_q.st.mst;
        end else if (addr == AW'(LAT_DW)) begin
            rdata[LAT_LSB +: LAT_W] = r_q.lat;
        end
    end

    assign cmd  = r_q.cmd;
    assign stat = r_q.st;
    assign lat  = r_q.lat;

endmodule

// File: rtl/pci_err_sig.sv
module pci_err_sig
    import pci_err_pkg::*;
#(
    parameter int unsigned PERR_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    input  logic ev_addr,
    input  logic ev_data,
    input  logic ev_spc,
    input  logic ev_mst,
    output logic perr_n,
    output logic serr_n,
    output logic set_det,
    output logic set_sig,
    output logic set_mst
);

    typedef struct packed {
        logic [PERR_LAT-1:0] pipe;
        logic                serr;
    } sig_t;

    sig_t s_d, s_q;
    logic perr_hit, serr_hit;
    logic [PERR_LAT-1:0] hit_vec;

    assign perr_hit = (ev_data || ev_mst) && cmd.par_en;
    assign serr_hit = (ev_addr && cmd.serr_en && cmd.par_en)
                   || (ev_spc && cmd.spc_en && cmd.serr_en);
    assign hit_vec  = PERR_LAT'(perr_hit);

    always_comb begin
        s_d      = s_q;
        s_d.pipe = (s_q.pipe << 1) | hit_vec;
        // a held cause yields separate one-cycle pulses
        s_d.serr = serr_hit && !s_q.serr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign perr_n  = !s_q.pipe[PERR_LAT-1];
    assign serr_n  = !s_q.serr;
    assign set_det = ev_addr || ev_data || ev_spc || ev_mst;
    assign set_sig = s_d.serr;
    assign set_mst = ev_mst && cmd.par_en;

endmodule

// File: rtl/pci_err_cmdmap.sv
module pci_err_cmdmap
    import pci_err_pkg::*;
(
    input  logic       mwi_en,
    input  logic [3:0] req,
    output logic [3:0] cmd_out
);

    always_comb begin
        cmd_out = req;
        if (req == BUS_MWI && !mwi_en) cmd_out = BUS_MWR;
    end

endmodule

// File: rtl/pci_err_ctl.sv
module pci_err_ctl
    import pci_err_pkg::*;
#(
    parameter int unsigned AW       = 6,
    parameter int unsigned LAT_W    = 8,
    parameter int unsigned PERR_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             ev_addr_perr,
    input  logic             ev_data_perr,
    input  logic             ev_spc_perr,
    input  logic             ev_mst_perr,
    input  logic [3:0]       req_cmd,
    output logic [3:0]       bus_cmd,
    output logic             perr_n,
    output logic             serr_n,
    output logic [LAT_W-1:0] lat_timer
);

    cmd_t  cmd;
    stat_t stat;
    logic  set_det, set_sig, set_mst;

    pci_err_regs #(.AW(AW), .LAT_W(LAT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .set_det (set_det),
        .set_sig (set_sig),
        .set_mst (set_mst),
        .cmd     (cmd),
        .stat    (stat),
        .lat     (lat_timer),
        .rdata   (cfg_rdata)
    );

    pci_err_sig #(.PERR_LAT(PERR_LAT)) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .ev_addr (ev_addr_perr),
        .ev_data (ev_data_perr),
        .ev_spc  (ev_spc_perr),
        .ev_mst  (ev_mst_perr),
        .perr_n  (perr_n),
        .serr_n  (serr_n),
        .set_det (set_det),
        .set_sig (set_sig),
        .set_mst (set_mst)
    );

    pci_err_cmdmap u_map (
        .mwi_en  (cmd.mwi_en),
        .req     (req_cmd),
        .cmd_out (bus_cmd)
    );

endmodule

// File: rtl/pci_err_chk.sv
module pci_err_chk
    import pci_err_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cmd_t       cmd,
    input stat_t      stat,
    input logic       ev_addr_perr,
    input logic       ev_data_perr,
    input logic       ev_spc_perr,
    input logic       ev_mst_perr,
    input logic [3:0] req_cmd,
    input logic [3:0] bus_cmd,
    input logic       perr_n,
    input logic       serr_n
);

    // R4
    perr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past((ev_data_perr || ev_mst_perr) && cmd.par_en, 2));

    // R5 R6
    serr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past((ev_addr_perr && cmd.serr_en && cmd.par_en)
                       || (ev_spc_perr && cmd.spc_en && cmd.serr_en)));

    // R7
    serr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n);

    // R8
    mwi_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == BUS_MWI && !cmd.mwi_en) |-> bus_cmd == BUS_MWR);

    // R9
    det_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr_perr || ev_data_perr || ev_spc_perr || ev_mst_perr) |=> stat.det);

    // R10
    sig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_n) |-> stat.sig);

    // R11
    mst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat.mst) |-> $past(ev_mst_perr && cmd.par_en));

endmodule

bind pci_err_ctl pci_err_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .stat         (stat),
    .ev_addr_perr (ev_addr_perr),
    .ev_data_perr (ev_data_perr),
    .ev_spc_perr  (ev_spc_perr),
    .ev_mst_perr  (ev_mst_perr),
    .req_cmd      (req_cmd),
    .bus_cmd      (bus_cmd),
    .perr_n       (perr_n),
    .serr_n       (serr_n)
);

// File: tb/pci_err_ctl_test.sv
module pci_err_ctl_test;

    localparam int PERIOD = 10;
    localparam int NV     = 11;
    // {c8,c6,c4,c3, ev_addr,ev_data,ev_spc,ev_mst, exp_perr,exp_serr, st15,st14,st8}
    localparam logic [12:0] VEC [NV] = '{
        13'b0000_0100_00_100,
        13'b0100_0100_10_100,
        13'b1100_1000_01_110,
        13'b1000_1000_00_100,
        13'b0100_1000_00_100,
        13'b1001_0010_01_110,
        13'b0001_0010_00_100,
        13'b1100_0010_00_100,
        13'b0100_0001_10_101,
        13'b0000_0001_00_100,
        13'b1111_0000_00_000
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ev_addr_perr = 1'b0, ev_data_perr = 1'b0;
    logic        ev_spc_perr = 1'b0, ev_mst_perr = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [3:0]  bus_cmd;
    logic        perr_n, serr_n;
    logic [7:0]  lat_timer;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    pci_err_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ev_addr_perr(ev_addr_perr), .ev_data_perr(ev_data_perr),
        .ev_spc_perr(ev_spc_perr), .ev_mst_perr(ev_mst_perr),
        .req_cmd(req_cmd), .bus_cmd(bus_cmd), .perr_n(perr_n),
        .serr_n(serr_n), .lat_timer(lat_timer)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr_cfg(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd_cfg(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 perr_n", {31'b0, perr_n}, 32'd1);
        chk("R1 serr_n", {31'b0, serr_n}, 32'd1);
        rd_cfg(6'd1, d); chk("R1 dword1", d, 32'h0);
        rd_cfg(6'd3, d); chk("R1 dword3", d, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            logic [31:0] w;
            v = VEC[i];
            w = 32'hC100_0000 | ({31'b0, v[12]} << 8) | ({31'b0, v[11]} << 6)
                | ({31'b0, v[10]} << 4) | ({31'b0, v[9]} << 3);
            wr_cfg(6'd1, 4'b1011, w);
            @(negedge clk);
            req_cmd = 4'b1111; #1;
            // R8 downgrade follows bit 4
            chk($sformatf("R8 vec%0d bus_cmd", i), {28'b0, bus_cmd},
                v[10] ? 32'hF : 32'h7);
            ev_addr_perr = v[8]; ev_data_perr = v[7];
            ev_spc_perr = v[6];  ev_mst_perr = v[5];
            @(negedge clk);
            ev_addr_perr = 0; ev_data_perr = 0; ev_spc_perr = 0; ev_mst_perr = 0;
            // R5 R6 serr one clock later; R4 perr not yet
            chk($sformatf("R5/R6 vec%0d serr_n", i), {31'b0, serr_n}, {31'b0, ~v[3]});
            chk($sformatf("R4 vec%0d perr_n early", i), {31'b0, perr_n}, 32'd1);
            @(negedge clk);
            chk($sformatf("R4 vec%0d perr_n", i), {31'b0, perr_n}, {31'b0, ~v[4]});
            chk($sformatf("R7 vec%0d serr_n release", i), {31'b0, serr_n}, 32'd1);
            rd_cfg(6'd1, d);
            // R9 R10 R11 status bits 31 30 24
            chk($sformatf("R9/R10/R11 vec%0d status", i), {29'b0, d[31], d[30], d[24]},
                {29'b0, v[2:0]});
            @(negedge clk);
        end

        // R2 reserved bits read 0
        wr_cfg(6'd1, 4'b0011, 32'h0000_FFFF);
        rd_cfg(6'd1, d); chk("R2 cmd bits", {16'b0, d[15:0]}, 32'h0000_0158);
        wr_cfg(6'd1, 4'b0010, 32'h0000_0000);
        rd_cfg(6'd1, d); chk("R2 lane1 only", {16'b0, d[15:0]}, 32'h0000_0058);

        // R8 non-MWI passthrough with bit 4 set and clear
        req_cmd = 4'b0110; #1;
        chk("R8 pass mwi_en", {28'b0, bus_cmd}, 32'h6);
        wr_cfg(6'd1, 4'b0001, 32'h0);
        req_cmd = 4'b0111; #1;
        chk("R8 pass plain", {28'b0, bus_cmd}, 32'h7);

        // R3 latency timer with byte enables
        wr_cfg(6'd3, 4'b0010, 32'h1234_A5CD);
        rd_cfg(6'd3, d); chk("R3 lat read", d, 32'h0000_A500);
        chk("R3 lat port", {24'b0, lat_timer}, 32'hA5);
        wr_cfg(6'd3, 4'b1101, 32'hFFFF_33FF);
        rd_cfg(6'd3, d); chk("R3 lat masked", d, 32'h0000_A500);

        // R7 held address error with c8 c6
        wr_cfg(6'd1, 4'b1011, 32'hC100_0140);
        ev_addr_perr = 1'b1;
        @(negedge clk); chk("R7 pulse1", {31'b0, serr_n}, 32'd0);
        @(negedge clk); chk("R7 gap", {31'b0, serr_n}, 32'd1);
        @(negedge clk); chk("R7 pulse2", {31'b0, serr_n}, 32'd0);
        ev_addr_perr = 1'b0;
        @(negedge clk);

        // R12 write of 0 keeps, event beats clear, 1 clears
        wr_cfg(6'd1, 4'b1000, 32'h0000_0000);
        rd_cfg(6'd1, d); chk("R12 zero write", {31'b0, d[31]}, 32'd1);
        ev_data_perr = 1'b1;
        wr_cfg(6'd1, 4'b1000, 32'h8000_0000);
        ev_data_perr = 1'b0;
        rd_cfg(6'd1, d); chk("R12 event wins", {31'b0, d[31]}, 32'd1);
        wr_cfg(6'd1, 4'b0111, 32'hC100_0000);
        rd_cfg(6'd1, d); chk("R12 no lane3", {31'b0, d[31]}, 32'd1);
        wr_cfg(6'd1, 4'b1000, 32'hC100_0000);
        rd_cfg(6'd1, d); chk("R12 cleared", {29'b0, d[31], d[30], d[24]}, 32'd0);

        // R4 parity response off: master error leaves perr high, R11 no bit 8
        wr_cfg(6'd1, 4'b0011, 32'h0000_0000);
        ev_mst_perr = 1'b1;
        @(negedge clk); ev_mst_perr = 1'b0;
        @(negedge clk); chk("R4 gated perr_n", {31'b0, perr_n}, 32'd1);
        rd_cfg(6'd1, d); chk("R11 gated st8", {31'b0, d[24]}, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule